// File: doc/BRIEF.md
# Masked Packed Zero-Extend Unit

This block widens unsigned packed integers for a vector datapath. It reads elements from the bottom of a source vector and places each one, padded with zeros, into a wider lane of the destination. Six widenings are available (8 to 16, 8 to 32, 8 to 64, 16 to 32, 16 to 64 and 32 to 64 bits) over result lengths of 128, 256 or 512 bits.

Three operating modes decide how the rest of the destination is treated. Legacy mode works on 128 bits and leaves the upper destination bits as they were. Wide mode writes every active lane and clears everything above the chosen length. Masked mode adds a per-lane write enable, with masked-off lanes either keeping their old value or being cleared. A 4-bit reserved field must hold all ones in the two newer modes. Illegal requests raise an invalid flag and return the old destination untouched.

The caller supplies the old destination value with each request. The result is registered and appears one cycle after the request.

Top module: `pzx_unit`

## Requirements
- R1: Destination lane n receives source element n, zero-extended, with element 0 at the lowest bits. Codes for `conv_sel` are 0 = 8 to 16, 1 = 8 to 32, 2 = 8 to 64, 3 = 16 to 32, 4 = 16 to 64 and 5 = 32 to 64 bits. No source sign bit ever reaches the upper part of a lane.
- R2: `len_sel` codes 0, 1 and 2 select 128, 256 and 512 result bits. The active lane count is that length divided by the destination element size; for example, 8 to 64 gives 2, 4 and 8 lanes.
- R3: In masked mode (`mode_sel` = 2) with `zero_en` = 0, an active lane whose `lane_mask` bit is clear keeps its `old_dst` bits. A lane whose mask bit is set takes the widened value.
- R4: In masked mode with `zero_en` = 1, an active lane whose mask bit is clear becomes all zeros.
- R5: In legacy mode (0) and wide mode (1), every active lane is written whatever `lane_mask` and `zero_en` hold.
- R6: In legacy mode, result bits 511:128 equal `old_dst` bits 511:128, and `rsv_field` has no effect.
- R7: In wide and masked modes, result bits at or above the selected length are zero.
- R8: In wide or masked mode, a `rsv_field` other than 4'b1111 sets `bad_op`, and the result equals `old_dst`.
- R9: The following requests set `bad_op` and return `old_dst` unchanged: legacy mode with a length other than 128, wide mode with 512, `len_sel` = 3, `mode_sel` = 3, and `conv_sel` of 6 or 7.
- R10: Mask bits at index equal to or above the active lane count do not affect the result.
- R11: `valid_out` follows `valid_in` one cycle later, and `result` and `bad_op` update only on accepted requests. A synchronous reset clears `valid_out`, `result` and `bad_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| src_vec | input | 256 | Source vector; elements taken from bit 0 upward |
| old_dst | input | 512 | Previous destination value |
| conv_sel | input | 3 | Widening type |
| len_sel | input | 2 | Result length |
| mode_sel | input | 2 | Legacy / wide / masked |
| lane_mask | input | 32 | Per-lane write enable, bit n for lane n |
| zero_en | input | 1 | 1 = clear masked-off lanes, 0 = keep them |
| rsv_field | input | 4 | Reserved specifier, must be 4'b1111 outside legacy mode |
| valid_out | output | 1 | Result strobe |
| result | output | 512 | Registered destination value |
| bad_op | output | 1 | Registered invalid-request flag |

## Verification
Each result, and its invalid flag, is due on the first rising edge after the request is presented. `valid_out` rises on that same edge. The bench drives each request on a falling edge and samples `result`, `bad_op` and `valid_out` on the next falling edge, so exactly one rising edge lies between stimulus and check. A hold check drops `valid_in` and changes `old_dst`, then confirms one falling edge later that `valid_out` is low and the result is unchanged.

// File: rtl/pzx_pkg.sv
package pzx_pkg;

  typedef enum logic [1:0] {
    MD_LEGACY = 2'd0,
    MD_WIDE   = 2'd1,
    MD_MASKED = 2'd2,
    MD_RSVD   = 2'd3
  } mode_e;

  localparam logic [2:0] CV_LAST = 3'd5;
  localparam logic [3:0] RSV_OK  = 4'b1111;

  // width of one source element for a widening code
  function automatic int src_bits(input logic [2:0] cv);
    case (cv)
      3'd0, 3'd1, 3'd2: return 8;
      3'd3, 3'd4:       return 16;
      default:          return 32;
    endcase
  endfunction

  // width of one destination lane for a widening code
  function automatic int dst_bits(input logic [2:0] cv);
    case (cv)
      3'd0:             return 16;
      3'd1, 3'd3:       return 32;
      default:          return 64;
    endcase
  endfunction

  // log2 of (destination lane width / 16)
  function automatic logic [1:0] lane_shift(input logic [2:0] cv);
    case (dst_bits(cv))
      16:      return 2'd0;
      32:      return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/pzx_legal.sv
module pzx_legal
  import pzx_pkg::*;
(
  input  logic [2:0] conv_sel,
  input  logic [1:0] len_sel,
  input  logic [1:0] mode_sel,
  input  logic [3:0] rsv_field,
  output logic       bad
);
  mode_e md;
  logic  len_bad, rsv_bad;

  always_comb begin
    md = mode_e'(mode_sel);
    case (md)
      MD_LEGACY: len_bad = (len_sel != 2'd0);
      MD_WIDE:   len_bad = (len_sel > 2'd1);
      MD_MASKED: len_bad = (len_sel == 2'd3);
      default:   len_bad = 1'b1;
    endcase
    rsv_bad = (md != MD_LEGACY) && (rsv_field != RSV_OK);
    bad     = len_bad || rsv_bad || (conv_sel > CV_LAST);
  end
endmodule

// File: rtl/pzx_widen.sv
module pzx_widen
  import pzx_pkg::*;
#(
  parameter  int VMAX  = 512,
  localparam int SRCW  = VMAX / 2,
  localparam int UNITS = VMAX / 16
) (
  input  logic [SRCW-1:0] src_vec,
  input  logic [2:0]      conv_sel,
  output logic [VMAX-1:0] wide
);
  // 16-bit slice u of the widened vector for one widening shape
  function automatic logic [15:0] slice16(input logic [SRCW-1:0] s,
                                          input int sb, input int db, input int u);
    int per, lane, part, off;
    logic [15:0] lo;
    per  = db / 16;
    lane = u / per;
    part = u % per;
    if (part * 16 >= sb) return '0;
    off = lane * sb + part * 16;
    lo  = 16'(s >> off);
    return (sb >= 16) ? lo : {8'h00, lo[7:0]};
  endfunction

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [15:0] val;
    always_comb begin
      val = '0;
      for (int k = 0; k <= int'(CV_LAST); k++) begin
        if (conv_sel == 3'(k))
          val = slice16(src_vec, src_bits(3'(k)), dst_bits(3'(k)), u);
      end
    end
    assign wide[16*u +: 16] = val;
  end
endmodule

// File: rtl/pzx_merge.sv
module pzx_merge
  import pzx_pkg::*;
#(
  parameter  int VMAX  = 512,
  localparam int UNITS = VMAX / 16,
  localparam int MASKW = VMAX / 16,
  localparam int LW    = $clog2(MASKW)
) (
  input  logic [VMAX-1:0]  wide,
  input  logic [VMAX-1:0]  old_dst,
  input  logic [2:0]       conv_sel,
  input  logic [1:0]       len_sel,
  input  logic [1:0]       mode_sel,
  input  logic [MASKW-1:0] lane_mask,
  input  logic             zero_en,
  input  logic             bad,
  output logic [VMAX-1:0]  merged
);
  int         vl_units;
  logic [1:0] lsh;
  logic       is_masked, is_legacy;

  always_comb begin
    vl_units  = 8 << len_sel;
    lsh       = lane_shift(conv_sel);
    is_masked = (mode_e'(mode_sel) == MD_MASKED);
    is_legacy = (mode_e'(mode_sel) == MD_LEGACY);
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [LW-1:0] lane;
    logic          take;
    logic [15:0]   val;
    always_comb begin
      lane = LW'(u >> lsh);
      take = !is_masked || lane_mask[lane];
      if (bad)
        val = old_dst[16*u +: 16];
      else if (u < vl_units)
        val = take ? wide[16*u +: 16] : (zero_en ? 16'h0000 : old_dst[16*u +: 16]);
      else
        val = is_legacy ? old_dst[16*u +: 16] : 16'h0000;
    end
    assign merged[16*u +: 16] = val;
  end
endmodule

// File: rtl/pzx_unit.sv
module pzx_unit #(
  parameter  int VMAX  = 512,
  localparam int SRCW  = VMAX / 2,
  localparam int MASKW = VMAX / 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [SRCW-1:0]  src_vec,
  input  logic [VMAX-1:0]  old_dst,
  input  logic [2:0]       conv_sel,
  input  logic [1:0]       len_sel,
  input  logic [1:0]       mode_sel,
  input  logic [MASKW-1:0] lane_mask,
  input  logic             zero_en,
  input  logic [3:0]       rsv_field,
  output logic             valid_out,
  output logic [VMAX-1:0]  result,
  output logic             bad_op
);
  logic            bad;
  logic [VMAX-1:0] wide, merged;

  pzx_legal u_legal (
    .conv_sel (conv_sel),
    .len_sel  (len_sel),
    .mode_sel (mode_sel),
    .rsv_field(rsv_field),
    .bad      (bad)
  );

  pzx_widen #(.VMAX(VMAX)) u_widen (
    .src_vec (src_vec),
    .conv_sel(conv_sel),
    .wide    (wide)
  );

  pzx_merge #(.VMAX(VMAX)) u_merge (
    .wide     (wide),
    .old_dst  (old_dst),
    .conv_sel (conv_sel),
    .len_sel  (len_sel),
    .mode_sel (mode_sel),
    .lane_mask(lane_mask),
    .zero_en  (zero_en),
    .bad      (bad),
    .merged   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
      bad_op    <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result <= merged;
        bad_op <= bad;
      end
    end
  end
endmodule

// File: rtl/pzx_unit_chk.sv
module pzx_unit_chk #(
  parameter  int VMAX  = 512,
  localparam int SRCW  = VMAX / 2,
  localparam int MASKW = VMAX / 16
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_in,
  input logic [SRCW-1:0]  src_vec,
  input logic [VMAX-1:0]  old_dst,
  input logic [2:0]       conv_sel,
  input logic [1:0]       len_sel,
  input logic [1:0]       mode_sel,
  input logic [MASKW-1:0] lane_mask,
  input logic             zero_en,
  input logic [3:0]       rsv_field,
  input logic             valid_out,
  input logic [VMAX-1:0]  result,
  input logic             bad_op
);
  logic rsv_ok, cv_ok;
  assign rsv_ok = (rsv_field == 4'b1111);
  assign cv_ok  = (conv_sel <= 3'd5);

  // R11
  handshake_lat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out && $stable(result));

  // R8
  rsv_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode_sel != 2'd0 && !rsv_ok) |=> bad_op && result == $past(old_dst));

  // R6
  legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode_sel == 2'd0) |=> result[VMAX-1:128] == $past(old_dst[VMAX-1:128]));

  // R7
  wide_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode_sel == 2'd1 && len_sel == 2'd1 && rsv_ok && cv_ok)
      |=> !bad_op && result[VMAX-1:256] == '0);

  // R4
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode_sel == 2'd2 && len_sel != 2'd3 && lane_mask == '0 && zero_en && rsv_ok && cv_ok)
      |=> result == '0);

  // R1
  lane0_b2w_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode_sel == 2'd1 && len_sel == 2'd0 && conv_sel == 3'd0 && rsv_ok)
      |=> result[15:0] == {8'h00, $past(src_vec[7:0])});
endmodule

bind pzx_unit pzx_unit_chk #(.VMAX(VMAX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_in (valid_in),
  .src_vec  (src_vec),
  .old_dst  (old_dst),
  .conv_sel (conv_sel),
  .len_sel  (len_sel),
  .mode_sel (mode_sel),
  .lane_mask(lane_mask),
  .zero_en  (zero_en),
  .rsv_field(rsv_field),
  .valid_out(valid_out),
  .result   (result),
  .bad_op   (bad_op)
);

// File: tb/pzx_unit_test.sv
module pzx_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int VMAX  = 512;
  localparam int SRCW  = VMAX / 2;
  localparam int MASKW = VMAX / 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             valid_in;
  logic [SRCW-1:0]  src_vec;
  logic [VMAX-1:0]  old_dst;
  logic [2:0]       conv_sel;
  logic [1:0]       len_sel;
  logic [1:0]       mode_sel;
  logic [MASKW-1:0] lane_mask;
  logic             zero_en;
  logic [3:0]       rsv_field;
  logic             valid_out;
  logic [VMAX-1:0]  result;
  logic             bad_op;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pzx_unit #(.VMAX(VMAX)) uut (.*);

  function automatic logic [VMAX-1:0] model(output logic bad);
    int sb, db, vl, lanes;
    logic [VMAX-1:0] r;
    case (conv_sel)
      3'd0: begin sb = 8;  db = 16; end
      3'd1: begin sb = 8;  db = 32; end
      3'd2: begin sb = 8;  db = 64; end
      3'd3: begin sb = 16; db = 32; end
      3'd4: begin sb = 16; db = 64; end
      default: begin sb = 32; db = 64; end
    endcase
    bad = (conv_sel > 3'd5) || (len_sel == 2'd3) || (mode_sel == 2'd3) ||
          (mode_sel == 2'd0 && len_sel != 2'd0) || (mode_sel == 2'd1 && len_sel == 2'd2) ||
          (mode_sel != 2'd0 && rsv_field != 4'hF);
    if (bad) return old_dst;
    vl    = 128 << len_sel;
    lanes = vl / db;
    r     = (mode_sel == 2'd0) ? old_dst : '0;
    for (int j = 0; j < lanes; j++) begin
      logic [63:0] e;
      e = 64'(src_vec >> (j * sb)) & ((64'd1 << sb) - 64'd1);
      for (int b = 0; b < db; b++) begin
        if (mode_sel == 2'd2 && !lane_mask[j])
          r[j*db + b] = zero_en ? 1'b0 : old_dst[j*db + b];
        else
          r[j*db + b] = e[b];
      end
    end
    return r;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // present current inputs for one request, check one cycle later
  task automatic check_vec(input string tag);
    logic [VMAX-1:0] exp;
    logic exp_bad;
    exp = model(exp_bad);
    valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    n_cmp++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s result got %h expected %h", tag, result, exp);
    end
    n_cmp++;
    if (bad_op !== exp_bad) begin
      n_bad++;
      $display("FAIL %s bad_op got %b expected %b", tag, bad_op, exp_bad);
    end
    n_cmp++;
    if (valid_out !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 valid_out got %b expected 1", valid_out);
    end
  endtask

  task automatic set_in(input logic [2:0] c, input logic [1:0] l, input logic [1:0] m,
                        input logic [MASKW-1:0] k, input logic z, input logic [3:0] rv);
    conv_sel = c; len_sel = l; mode_sel = m; lane_mask = k; zero_en = z; rsv_field = rv;
  endtask

  task automatic rand_data();
    for (int i = 0; i < SRCW / 32; i++) src_vec[32*i +: 32] = $urandom;
    for (int i = 0; i < VMAX / 32; i++) old_dst[32*i +: 32] = $urandom;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog expired got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [VMAX-1:0] held;
    rst = 1'b1; valid_in = 1'b0;
    src_vec = '0; old_dst = '1;
    set_in(3'd0, 2'd0, 2'd1, '1, 1'b0, 4'hF);
    repeat (3) @(negedge clk);
    // R11 reset state
    n_cmp++;
    if (valid_out !== 1'b0 || result !== '0 || bad_op !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset got %b/%h/%b expected 0/0/0", valid_out, result, bad_op);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1: elements with top bit set must not spread sign bits
    src_vec = {8{32'hF0F1_8283}}; old_dst = '1;
    set_in(3'd5, 2'd1, 2'd1, '0, 1'b1, 4'hF);
    check_vec("R1");
    set_in(3'd0, 2'd0, 2'd1, '0, 1'b0, 4'hF);
    check_vec("R1");
    // R2: 8 lanes of 64 bits at 512
    rand_data();
    set_in(3'd2, 2'd2, 2'd2, '1, 1'b0, 4'hF);
    check_vec("R2");
    // R7: wide 256 clears above
    set_in(3'd3, 2'd1, 2'd1, '1, 1'b0, 4'hF);
    check_vec("R7");
    // R10: only lanes 0 and 1 active; high mask bits set but 0/1 clear
    set_in(3'd2, 2'd0, 2'd2, 32'hFFFF_FFFC, 1'b1, 4'hF);
    check_vec("R10");
    set_in(3'd4, 2'd0, 2'd2, 32'hFFFF_FFFD, 1'b0, 4'hF);
    check_vec("R10");
    // R6: legacy ignores reserved field
    set_in(3'd1, 2'd0, 2'd0, '0, 1'b1, 4'h3);
    check_vec("R6");
    // R9 and R8 directed
    set_in(3'd0, 2'd1, 2'd0, '1, 1'b0, 4'hF);
    check_vec("R9");
    set_in(3'd0, 2'd0, 2'd1, '1, 1'b0, 4'hE);
    check_vec("R8");

    // R11: hold when no request
    held = result;
    old_dst = ~old_dst;
    @(negedge clk);
    n_cmp++;
    if (valid_out !== 1'b0 || result !== held) begin
      n_bad++;
      $display("FAIL R11 hold got %b/%h expected 0/%h", valid_out, result, held);
    end

    // sweep: R3 R4 R5 R6 R8 R9 by class
    for (int c = 0; c < 8; c++)
      for (int l = 0; l < 4; l++)
        for (int m = 0; m < 4; m++)
          for (int z = 0; z < 2; z++)
            for (int mi = 0; mi < 3; mi++)
              for (int ri = 0; ri < 2; ri++) begin
                string tag;
                logic [MASKW-1:0] k;
                logic [3:0] rv;
                rand_data();
                k  = (mi == 0) ? '1 : (mi == 1) ? MASKW'($urandom) : '0;
                rv = (ri == 0) ? 4'hF : 4'($urandom % 15);
                set_in(3'(c), 2'(l), 2'(m), k, z[0], rv);
                if (c > 5 || l == 3 || m == 3 || (m == 0 && l != 0) || (m == 1 && l == 2))
                  tag = "R9";
                else if (m != 0 && rv != 4'hF) tag = "R8";
                else if (m == 0) tag = "R6";
                else if (m == 1) tag = "R5";
                else if (z == 1) tag = "R4";
                else tag = "R3";
                check_vec(tag);
              end

    done = 1;
    summary();
    $finish;
  end
endmodule